// File: doc/BRIEF.md
# Memory Channel Event Counter Unit

This block holds four programmable event counters for a single memory channel. Each counter has its own 16-bit control word: the low byte picks an event code and the high byte is a unit mask. Every cycle the channel presents three kinds of status: a pulse for each corrected ECC error, a vector that names the major mode it is in (read, write, partial, isochronous), and one slow power-down flag per rank. Each counter adds at most one per cycle when its selected condition holds.

Counting is controlled by a two-state machine. **HALT** is the reset state. In this state counters keep their values. **COUNT** lets counters advance. The transition **GO** (HALT to COUNT) is taken at a clock edge that samples `glb_en` high. The transition **STOP** (COUNT to HALT) is taken at an edge that samples `glb_en` low. Because of this, an event is counted only at an edge where the state is already COUNT. Software reads any counter and its sticky wrap flag through a combinational read port selected by `rd_idx`.

Top module: `mcpm_unit`

## Requirements
- R1: After reset every counter reads zero, every wrap flag is clear and the run state is HALT.
- R2: A write with `cfg_we` high stores `cfg_wdata` as the control word of counter `cfg_idx` (event code in bits [7:0], unit mask in bits [15:8]) and zeroes that counter and its wrap flag at the same edge. The other counters are not affected.
- R3: Event code 0x09 adds one in each counting cycle where `ev_ecc_fix` is high. The unit mask has no effect.
- R4: Event code 0x07 adds one in each counting cycle where `umask[3:0] & ev_mode` is nonzero. The bits of `ev_mode` and `umask` are: bit 0 read, bit 1 write, bit 2 partial, bit 3 isochronous. Mask bits [7:4] are ignored.
- R5: Event code 0x84 adds one only in counting cycles where every bit of `ev_rank_slow` is high. The unit mask has no effect.
- R6: A counter holds its value if its event code is any value other than 0x09, 0x07 or 0x84, or if its code is 0x07 with `umask[3:0]` equal to zero.
- R7: A counter never changes by more than one per cycle, except when it is cleared.
- R8: Counters advance only in state COUNT. The state changes through GO and STOP as described above.
- R9: When a counter at all-ones is incremented, it wraps to zero and sets its sticky wrap flag. Only a clear or a control write resets the flag.
- R10: `glb_clr` zeroes all counters and wrap flags. It takes priority over both increments and the zeroing done by a control write, but the control word is still stored.
- R11: `rd_data` and `rd_ovf` show counter `rd_idx` with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_idx | input | 2 | Counter addressed by the write |
| cfg_wdata | input | 16 | Control word: unit mask [15:8], event code [7:0] |
| glb_en | input | 1 | Run request sampled by the state machine |
| glb_clr | input | 1 | Zero all counters and wrap flags |
| rd_idx | input | 2 | Counter shown on the read port |
| rd_data | output | CNT_W (48) | Value of the selected counter |
| rd_ovf | output | 1 | Sticky wrap flag of the selected counter |
| ev_ecc_fix | input | 1 | One corrected ECC error in this cycle |
| ev_mode | input | 4 | Major mode status: read, write, partial, isochronous |
| ev_rank_slow | input | NRANK (4) | Per-rank slow power-down flag |

## Verification
Embedded assertions check, on every cycle, the following rules: the per-cycle step limit, wrap-flag stickiness, the flag being set on wrap, the priority of the global clear, and that a counter is frozen in HALT, under an unknown code, or while any rank is awake under code 0x84. They cannot show that the correct event was picked for each mask combination, or that the count totals match over long runs. The bench's reference model covers those. It recomputes every counter from the requirements and compares all four on every clock, under random events, reconfiguration, enable toggling and a forced wrap.

// File: rtl/mcpm_pkg.sv
package mcpm_pkg;
    localparam logic [7:0] EV_ECC  = 8'h09;
    localparam logic [7:0] EV_MODE = 8'h07;
    localparam logic [7:0] EV_SLOW = 8'h84;
    localparam int MODE_W = 4;

    typedef struct packed {
        logic [7:0] umask;
        logic [7:0] code;
    } ctl_t;

    typedef enum logic {ST_HALT, ST_COUNT} run_st_e;
endpackage

// File: rtl/mcpm_evt_sel.sv
module mcpm_evt_sel
    import mcpm_pkg::*;
#(
    parameter int NRANK = 4
) (
    input  ctl_t              ctl,
    input  logic              ev_ecc_fix,
    input  logic [MODE_W-1:0] ev_mode,
    input  logic [NRANK-1:0]  ev_rank_slow,
    output logic              hit
);
    logic all_slow;
    assign all_slow = &ev_rank_slow;

    always_comb begin
        unique case (ctl.code)
            EV_ECC:  hit = ev_ecc_fix;
            EV_MODE: hit = |(ctl.umask[MODE_W-1:0] & ev_mode);
            EV_SLOW: hit = all_slow;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/mcpm_ctr.sv
module mcpm_ctr #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic [CNT_W:0] sum;
    assign sum = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (clr || ld) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (adv) begin
            cnt <= sum[CNT_W-1:0];
            if (sum[CNT_W]) ovf <= 1'b1;
        end
    end

    // R7: step of at most one
    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !ld |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));
    // R9: flag is sticky
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !clr && !ld |=> ovf);
    // R9: wrap sets flag and zeroes count
    a_r9_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !clr && !ld && (&cnt) |=> ovf && (cnt == '0));
    // R10: clear wins
    a_r10_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0) && !ovf);
endmodule

// File: rtl/mcpm_unit.sv
module mcpm_unit
    import mcpm_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int NRANK = 4,
    parameter int NCTR  = 4,
    localparam int IDX_W = (NCTR > 1) ? $clog2(NCTR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [15:0]       cfg_wdata,
    input  logic              glb_en,
    input  logic              glb_clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  rd_data,
    output logic              rd_ovf,
    input  logic              ev_ecc_fix,
    input  logic [MODE_W-1:0] ev_mode,
    input  logic [NRANK-1:0]  ev_rank_slow
);
    run_st_e state, state_nx;
    logic    run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        run      = 1'b0;
        unique case (state)
            ST_HALT: begin
                if (glb_en) state_nx = ST_COUNT;   // GO
            end
            ST_COUNT: begin
                run = 1'b1;
                if (!glb_en) state_nx = ST_HALT;   // STOP
            end
            default: state_nx = ST_HALT;
        endcase
    end

    ctl_t             ctl   [NCTR];
    logic [CNT_W-1:0] cnt_a [NCTR];
    logic             ovf_a [NCTR];

    for (genvar i = 0; i < NCTR; i++) begin : g_ctr
        logic ld, hit;
        assign ld = cfg_we && (cfg_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  ctl[i] <= '0;
            else if (ld) ctl[i] <= ctl_t'(cfg_wdata);
        end

        mcpm_evt_sel #(.NRANK(NRANK)) u_sel (
            .ctl          (ctl[i]),
            .ev_ecc_fix   (ev_ecc_fix),
            .ev_mode      (ev_mode),
            .ev_rank_slow (ev_rank_slow),
            .hit          (hit)
        );

        mcpm_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (glb_clr),
            .ld    (ld),
            .adv   (run && hit),
            .cnt   (cnt_a[i]),
            .ovf   (ovf_a[i])
        );

        // R8: frozen outside COUNT
        a_r8_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_HALT) && !glb_clr && !ld |=> $stable(cnt_a[i]));
        // R5: not every rank slow under code 0x84 -> hold
        a_r5_rank_gate: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl[i].code == EV_SLOW) && !(&ev_rank_slow) && !glb_clr && !ld
            |=> $stable(cnt_a[i]));
        // R6: unknown code -> hold
        a_r6_unknown_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl[i].code != EV_ECC) && (ctl[i].code != EV_MODE) &&
            (ctl[i].code != EV_SLOW) && !glb_clr && !ld |=> $stable(cnt_a[i]));
    end

    assign rd_data = cnt_a[rd_idx];
    assign rd_ovf  = ovf_a[rd_idx];

    // R8: GO / STOP transitions
    a_r8_go: assert property (@(posedge clk) disable iff (!rst_n)
        glb_en |=> state == ST_COUNT);
    a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> state == ST_HALT);
endmodule

// File: tb/tb_mcpm_unit.sv
`timescale 1ns/1ps
module tb_mcpm_unit;
    localparam int CNT_W = 8;
    localparam int NRANK = 4;
    localparam longint MAXV = (64'd1 << CNT_W) - 1;

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0, glb_en = 0, glb_clr = 0, ev_ecc_fix = 0;
    logic [1:0] cfg_idx = 0, rd_idx = 0;
    logic [15:0] cfg_wdata = 0;
    logic [3:0] ev_mode = 0;
    logic [NRANK-1:0] ev_rank_slow = 0;
    logic [CNT_W-1:0] rd_data;
    logic rd_ovf;

    always #5 clk = ~clk;

    mcpm_unit #(.CNT_W(CNT_W), .NRANK(NRANK), .NCTR(4)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .glb_en(glb_en), .glb_clr(glb_clr),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_ovf(rd_ovf),
        .ev_ecc_fix(ev_ecc_fix), .ev_mode(ev_mode), .ev_rank_slow(ev_rank_slow));

    int n_chk = 0, n_fail = 0;
    string tag = "R1";
    longint m_cnt [4];
    bit     m_ovf [4];
    logic [15:0] m_ctl [4];
    bit     m_run = 0;

    // reference model
    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 4; i++) begin
                bit h;
                case (m_ctl[i][7:0])
                    8'h09:   h = ev_ecc_fix;
                    8'h07:   h = (m_ctl[i][11:8] & ev_mode) != 0;
                    8'h84:   h = (ev_rank_slow == '1);
                    default: h = 0;
                endcase
                if (glb_clr) begin
                    m_cnt[i] = 0; m_ovf[i] = 0;
                end else if (cfg_we && cfg_idx == i[1:0]) begin
                    m_cnt[i] = 0; m_ovf[i] = 0;
                end else if (m_run && h) begin
                    if (m_cnt[i] == MAXV) begin m_cnt[i] = 0; m_ovf[i] = 1; end
                    else m_cnt[i] = m_cnt[i] + 1;
                end
                if (cfg_we && cfg_idx == i[1:0]) m_ctl[i] = cfg_wdata;
            end
            m_run = glb_en;
        end
    end

    task automatic compare_all();
        for (int i = 0; i < 4; i++) begin
            rd_idx = i[1:0];
            #0.1;
            n_chk++;
            if (rd_data != m_cnt[i][CNT_W-1:0] || rd_ovf != m_ovf[i]) begin
                n_fail++;
                $display("FAIL %s/R11 ctr%0d: got %0d ovf %0b, expected %0d ovf %0b",
                         tag, i, rd_data, rd_ovf, m_cnt[i], m_ovf[i]);
            end
        end
    endtask

    // compare on every clock, at the falling edge
    bit go = 0;
    always @(negedge clk) if (go) compare_all();

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(int idx, logic [15:0] w);
        cfg_we = 1; cfg_idx = idx[1:0]; cfg_wdata = w;
        cyc(1);
        cfg_we = 0;
    endtask

    task automatic rand_ev(int n);
        repeat (n) begin
            ev_ecc_fix   = 1'($urandom);
            ev_mode      = 4'($urandom);
            ev_rank_slow = ($urandom % 3 == 0) ? '1 : NRANK'($urandom);
            cyc(1);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_ovf[i] = 0; m_ctl[i] = 0; end
        #23 rst_n = 1;
        #1;
        tag = "R1";
        compare_all();
        go = 1;

        tag = "R2";
        wr(0, 16'hFF09);
        wr(1, 16'h0607);
        wr(2, 16'h0084);
        wr(3, 16'h0155);
        glb_en = 1;
        tag = "R3"; rand_ev(30);
        tag = "R4"; rand_ev(30);
        tag = "R5";
        repeat (4) begin ev_rank_slow = '1; cyc(3); ev_rank_slow = 4'b1101; cyc(2); end
        tag = "R6";
        wr(1, 16'hF007);
        rand_ev(20);
        wr(1, 16'h0907);
        tag = "R4"; rand_ev(20);
        tag = "R8";
        glb_en = 0; rand_ev(10);
        glb_en = 1; rand_ev(10);
        tag = "R2"; rand_ev(3); wr(2, 16'h0809); rand_ev(10);
        tag = "R10";
        glb_clr = 1; cfg_we = 1; cfg_idx = 2'd3; cfg_wdata = 16'h0007 | 16'h0100;
        cyc(1);
        glb_clr = 0; cfg_we = 0;
        rand_ev(15);
        tag = "R9";
        wr(0, 16'h0009);
        ev_ecc_fix = 1;
        cyc(300);
        ev_ecc_fix = 0;
        cyc(3);
        tag = "R7"; rand_ev(40);
        go = 0;
        #5;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule